// File: doc/BRIEF.md
# Diagonal Parity Code Generator and Checker

This block protects a stream of 16-bit words on a packet-oriented parallel link with a 4-bit code built from parity taken along diagonals. The diagonals run across successive words rather than within one word. Each accepted word is XORed into a 16-bit running sum that is rotated left by one bit first. At every control word the sum is folded down to a nibble. The control word joins the sum with its code field taken as all ones. After a control word the sum starts again from zero.

A build-time parameter selects the role. On the transmit side (generate) the block passes the stream through and writes the computed code into the code field of each control word. On the receive side (check) the stream passes through unchanged. The code field of each control word is compared with the locally computed code, and a one-cycle error pulse flags any difference. Both roles delay the stream by one register stage.

Top module: `dip_parity`

## Requirements
- R1: While rst_ni is low, valid_o, ctrl_o, code_o and err_o are 0 and the running sum is cleared, so the first window after reset starts from zero.
- R2: On each cycle with valid_i high, the running sum becomes (sum rotated left by one bit) XOR the effective word. Cycles with valid_i low leave the sum unchanged, whatever data_i and ctrl_i carry.
- R3: A word accepted with ctrl_i high is a control word. Its code field is data bits [3:0], and it enters the sum with those four bits forced to 1.
- R4: The code is the high byte XOR the low byte of the final sum, and then the high nibble XOR the low nibble of that byte.
- R5: A window covers every valid word after the previous control word (or after reset) up to and including the current control word. The sum clears after each control word, so two control words in a row each form a one-word window.
- R6: code_o takes the code of a control word one cycle after that word is accepted. It holds that value until the next control word.
- R7: In generate mode, data_o is data_i delayed by one cycle, with bits [3:0] of a control word replaced by its code. All other words pass unchanged.
- R8: In check mode, data_o is data_i delayed by one cycle and unchanged. err_o is high for exactly the cycle after a control word whose bits [3:0] differ from the computed code, and low otherwise.
- R9: A single bit flipped anywhere in a window between a generator and a checker makes the checker raise err_o for that window's control word.
- R10: valid_o is valid_i delayed by one cycle, and ctrl_o is (valid_i AND ctrl_i) delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word strobe |
| ctrl_i | input | 1 | Input word is a code-bearing control word |
| data_i | input | DATA_W | Input word |
| valid_o | output | 1 | Output word strobe |
| ctrl_o | output | 1 | Output word is a control word |
| data_o | output | DATA_W | Output word (code inserted in generate mode) |
| code_o | output | CODE_W | Code of the most recent window |
| err_o | output | 1 | Code mismatch pulse (check mode only) |

## Verification
The bench builds two instances with the default widths, DATA_W=16 and CODE_W=4. One is a generator and one is a checker, and the generator's output feeds the checker's input. The two-stage fold therefore reduces to the true nibble case, and every inserted code is verified again by the checker. A mask on the link between the instances flips one chosen bit in a data word or in a control word. This brings single-bit error detection at every bit position within reach, including the code field itself. Random burst lengths, idle cycles carrying garbage data and back-to-back control words exercise the window boundaries.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic {
    DIP_GEN   = 1'b0,
    DIP_CHECK = 1'b1
  } dip_mode_e;
endpackage

// File: rtl/dip_accum.sv
module dip_accum #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam logic [DATA_W-1:0] FieldOnes = {{(DATA_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] word_eff;

  // code field counts as all ones inside control words
  assign word_eff = ctrl_i ? (data_i | FieldOnes) : data_i;
  assign sum_o    = {acc_q[DATA_W-2:0], acc_q[DATA_W-1]} ^ word_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= ctrl_i ? '0 : sum_o;
  end

  p_acc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i) |=> (acc_q == '0));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q));
endmodule

// File: rtl/dip_fold.sv
module dip_fold #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  sum_i,
  output logic [OUT_W-1:0] code_o
);
  localparam int Parts = IN_W / OUT_W;

  logic [OUT_W-1:0] chain [Parts+1];

  assign chain[0] = '0;
  // byte-then-nibble fold is the XOR of all OUT_W-wide slices
  for (genvar g = 0; g < Parts; g++) begin : g_slice
    assign chain[g+1] = chain[g] ^ sum_i[g*OUT_W +: OUT_W];
  end

  assign code_o = chain[Parts];
endmodule

// File: rtl/dip_out.sv
module dip_out
  import dip_pkg::*;
#(
  parameter int        DATA_W = 16,
  parameter int        CODE_W = 4,
  parameter dip_mode_e MODE   = DIP_GEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic              ctrl_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o
);
  logic              is_ctrl;
  logic [DATA_W-1:0] word_nxt;
  logic              err_nxt;

  assign is_ctrl = valid_i && ctrl_i;

  if (MODE == DIP_GEN) begin : g_gen
    assign word_nxt = is_ctrl ? {data_i[DATA_W-1:CODE_W], code_i} : data_i;
    assign err_nxt  = 1'b0;
  end else begin : g_chk
    assign word_nxt = data_i;
    assign err_nxt  = is_ctrl && (data_i[CODE_W-1:0] != code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ctrl_o  <= 1'b0;
      data_o  <= '0;
      code_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ctrl_o  <= is_ctrl;
      data_o  <= word_nxt;
      err_o   <= err_nxt;
      if (is_ctrl) code_o <= code_i;
    end
  end

  p_vld_pipe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_code_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i && ctrl_i) |-> $stable(code_o));

  p_err_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(valid_i && ctrl_i));

  if (MODE == DIP_GEN) begin : g_gen_chk
    p_field_ins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && ctrl_o) |-> (data_o[CODE_W-1:0] == code_o));
  end
endmodule

// File: rtl/dip_parity.sv
module dip_parity
  import dip_pkg::*;
#(
  parameter int        DATA_W = 16,
  parameter int        CODE_W = 4,
  parameter dip_mode_e MODE   = DIP_GEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              ctrl_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o
);
  logic [DATA_W-1:0] sum;
  logic [CODE_W-1:0] code;

  dip_accum #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ctrl_i  (ctrl_i),
    .data_i  (data_i),
    .sum_o   (sum)
  );

  dip_fold #(.IN_W(DATA_W), .OUT_W(CODE_W)) u_fold (
    .sum_i  (sum),
    .code_o (code)
  );

  dip_out #(.DATA_W(DATA_W), .CODE_W(CODE_W), .MODE(MODE)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ctrl_i  (ctrl_i),
    .data_i  (data_i),
    .code_i  (code),
    .valid_o (valid_o),
    .ctrl_o  (ctrl_o),
    .data_o  (data_o),
    .code_o  (code_o),
    .err_o   (err_o)
  );
endmodule

// File: tb/dip_parity_tb.sv
module dip_parity_tb;
  import dip_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, ctrl_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [15:0] link_mask = '0;

  logic        g_valid_o, g_ctrl_o, g_err_o;
  logic [15:0] g_data_o;
  logic [3:0]  g_code_o;
  logic        k_valid_o, k_ctrl_o, k_err_o;
  logic [15:0] k_data_o;
  logic [3:0]  k_code_o;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  dip_parity #(.DATA_W(16), .CODE_W(4), .MODE(DIP_GEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ctrl_i(ctrl_i), .data_i(data_i),
    .valid_o(g_valid_o), .ctrl_o(g_ctrl_o), .data_o(g_data_o), .code_o(g_code_o), .err_o(g_err_o)
  );

  dip_parity #(.DATA_W(16), .CODE_W(4), .MODE(DIP_CHECK)) u_dut_chk (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(g_valid_o), .ctrl_i(g_ctrl_o),
    .data_i(g_data_o ^ link_mask),
    .valid_o(k_valid_o), .ctrl_o(k_ctrl_o), .data_o(k_data_o), .code_o(k_code_o), .err_o(k_err_o)
  );

  function automatic logic [15:0] rotl(input logic [15:0] a);
    return {a[14:0], a[15]};
  endfunction

  function automatic logic [3:0] fold(input logic [15:0] s);
    logic [7:0] b;
    b = s[15:8] ^ s[7:0];
    return b[7:4] ^ b[3:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model state
  logic [15:0] gacc = '0, kacc = '0;
  logic        ge_vld = 0, ge_ctrl = 0;
  logic [15:0] ge_data = '0;
  logic [3:0]  ge_code = '0;
  logic        ke_vld = 0, ke_err = 0, ke_chk9 = 0;
  logic [15:0] ke_data = '0;
  logic [3:0]  ke_code = '0;
  logic [15:0] pf = '0;
  logic        pflag9 = 0;

  task automatic step(input logic v, input logic c, input logic [15:0] d,
                      input logic [15:0] f, input logic flag9);
    logic [15:0] w;
    logic [3:0]  cc;
    check("R10 gen valid", {31'd0, g_valid_o}, {31'd0, ge_vld});
    if (ge_vld) begin
      check("R10 gen ctrl", {31'd0, g_ctrl_o}, {31'd0, ge_ctrl});
      check("R7 gen data", {16'd0, g_data_o}, {16'd0, ge_data});
    end
    check("R6 gen code", {28'd0, g_code_o}, {28'd0, ge_code});
    check("R8 chk err", {31'd0, k_err_o}, {31'd0, ke_err});
    if (ke_chk9) check("R9 single flip seen", {31'd0, k_err_o}, 32'd1);
    check("R6 chk code", {28'd0, k_code_o}, {28'd0, ke_code});
    check("R10 chk valid", {31'd0, k_valid_o}, {31'd0, ke_vld});
    if (ke_vld) check("R8 chk data", {16'd0, k_data_o}, {16'd0, ke_data});
    // checker expectations for the word the generator is presenting now
    link_mask = ge_vld ? pf : '0;
    ke_vld = ge_vld; ke_err = 0; ke_chk9 = 0;
    if (ge_vld) begin
      w = ge_data ^ pf;
      ke_data = w;
      if (ge_ctrl) begin
        cc = fold(rotl(kacc) ^ (w | 16'h000F));
        ke_code = cc; ke_err = (cc != w[3:0]); ke_chk9 = pflag9; kacc = '0;
      end else kacc = rotl(kacc) ^ w;
    end
    valid_i = v; ctrl_i = c; data_i = d;
    ge_vld = v; ge_ctrl = v & c; ge_data = d;
    if (v) begin
      if (c) begin
        cc = fold(rotl(gacc) ^ (d | 16'h000F));
        ge_code = cc; ge_data = {d[15:4], cc}; gacc = '0;
      end else gacc = rotl(gacc) ^ d;
    end
    pf = v ? f : '0;
    pflag9 = v & c & flag9;
    @(negedge clk);
  endtask

  // n data words then one control word; optional single flip at word fpos (n = control word)
  task automatic burst(input int n, input int fpos, input int fbit, input bit idles);
    logic [15:0] m;
    for (int i = 0; i < n; i++) begin
      if (idles && ($urandom % 4 == 0)) step(0, $urandom % 2, 16'($urandom), 16'hFFFF, 0);
      m = (fpos == i) ? (16'd1 << fbit) : '0;
      step(1, 0, 16'($urandom), m, 0);
    end
    m = (fpos == n) ? (16'd1 << fbit) : '0;
    step(1, 1, 16'($urandom), m, fpos >= 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d1f));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, g_valid_o}, 0);
    check("R1 code", {28'd0, g_code_o}, 0);
    check("R1 err", {31'd0, k_err_o}, 0);
    check("R1 chk code", {28'd0, k_code_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1/R5: control word alone right after reset: code = 1^2^3^F
    step(1, 1, 16'h1230, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R1 R3 R4 first window", {28'd0, g_code_o}, 32'h0000_000F ^ 32'd1 ^ 32'd2 ^ 32'd3);
    // R2: idle cycles carrying garbage and ctrl must not touch the sum
    step(1, 0, 16'hA5A5, 0, 0);
    step(0, 1, 16'hFFFF, 0, 0);
    step(0, 0, 16'h1234, 0, 0);
    step(1, 0, 16'h0F0F, 0, 0);
    step(1, 1, 16'h8000, 0, 0);
    // R5: back-to-back control words
    step(1, 1, 16'h0000, 0, 0);
    step(1, 1, 16'hFFF0, 0, 0);
    step(1, 1, 16'h4321, 0, 0);
    // all-ones burst
    for (int i = 0; i < 5; i++) step(1, 0, 16'hFFFF, 0, 0);
    step(1, 1, 16'hFFFF, 0, 0);
    // R9: single flip at every position, in a data word and in the control word
    for (int b = 0; b < 16; b++) begin
      burst(2, 1, b, 0);
      burst(2, 2, b, 0);
    end
    // random bursts
    for (int k = 0; k < 400; k++) begin
      int n;
      n = $urandom % 21;
      if ($urandom % 4 == 0) burst(n, $urandom % (n + 1), $urandom % 16, 1);
      else burst(n, -1, 0, 1);
    end
    repeat (4) step(0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule